// File: doc/BRIEF.md
# Scaled Index Shift-Add Unit

An integer execute unit that forms a base value plus a left-shifted index in one pass. The shift is the 2-bit scale field plus one, so the index is always multiplied by 2, 4, 8 or 16. A shift of zero cannot be requested. The index is taken in one of three ways:
- the whole 64-bit operand;
- the low 32-bit word, sign-extended;
- the low 32-bit word, zero-extended.

The word forms suit address arithmetic where the offset into a structure is a 32-bit integer. Any bits shifted above bit 63, and any carry out of the add, are dropped, so the result wraps modulo 2^64.

Operations enter on a valid/ready stream and leave on another. The input handshake completes when `in_valid` and `in_ready` are both high on a rising clock edge. The output handshake completes when `out_valid` and `out_ready` are both high.

With the default registered stage, the result of an accepted operation appears one clock after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output beat is held stable and no new operation is taken. Setting `REG_OUT` to 0 makes the unit combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

The unit also keeps a 3-bit condition code. An operation with the record bit set updates it. Any other operation leaves it as it was.

Top module: `scaled_index_unit`

## Requirements
- R1: The shift applied to the extended index is `in_scale + 1`, so scale codes 0, 1, 2 and 3 multiply the index by 2, 4, 8 and 16.
- R2: Variant code 0 (full) adds the whole 64-bit index, shifted, to the base. The sum is taken modulo 2^64: shifted-out bits and the carry out are discarded.
- R3: Variant code 1 (signed word) sign-extends index bits [31:0] to 64 bits, then shifts and adds.
- R4: Variant code 2 (unsigned word) zero-extends index bits [31:0] to 64 bits, then shifts and adds.
- R5: Variant code 3 is reserved. It gives `out_result` = 0 and `out_illegal` = 1, and it never changes the condition code. For codes 0 to 2, `out_illegal` = 0.
- R6: An accepted legal operation with `in_record` = 1 sets the condition code from the signed 64-bit result:
  - 3'b100 when the result is negative;
  - 3'b010 when it is positive;
  - 3'b001 when it is zero.
- R7: An accepted operation with `in_record` = 0 leaves `out_cc` unchanged.
- R8: With `REG_OUT` = 1, the result appears on the output one clock after the input handshake, and `out_valid` rises at that same edge. If no new operation is accepted when the output beat transfers, `out_valid` falls at the next edge.
- R9: With `REG_OUT` = 1, `in_ready` = `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, `out_result`, `out_illegal` and `out_cc` hold stable.
- R10: A synchronous reset clears `out_valid` and sets the condition code to 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_base | input | 64 | Base operand |
| in_index | input | 64 | Index operand |
| in_scale | input | 2 | Scale code; shift = code + 1 |
| in_variant | input | 2 | 0 full, 1 signed word, 2 unsigned word, 3 reserved |
| in_record | input | 1 | Update the condition code |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_result | output | 64 | Wrapped sum |
| out_illegal | output | 1 | Reserved variant was used |
| out_cc | output | 3 | Condition code {negative, positive, zero} |

## Verification
The directed cases do the following:
- They walk all four scale codes with an index of one. This separates each shift amount from its neighbours and from a shift of zero.
- They use an index whose low word is all ones and whose high word is non-zero. This pattern tells the three variants apart: only the full variant sees the high word, and only the signed-word variant produces a negative offset.
- A base of all ones and an index with its top bit set expose any missing wrap or any leak of a carry or shifted-out bit.
- Record-form operations with zero, positive and negative results, followed by non-record and reserved operations, separate an update of the condition code from a hold.

Random operands from a fixed seed then run back-to-back against a model in the bench. A stalled consumer shows whether the output beat and the input ready obey back-pressure.

// File: rtl/sia_pkg.sv
package sia_pkg;

  typedef enum logic [1:0] {
    VAR_FULL  = 2'd0,
    VAR_SWORD = 2'd1,
    VAR_UWORD = 2'd2,
    VAR_RSVD  = 2'd3
  } sia_variant_e;

  localparam int CC_W = 3;
  localparam logic [CC_W-1:0] CC_NEG  = 3'b100;
  localparam logic [CC_W-1:0] CC_POS  = 3'b010;
  localparam logic [CC_W-1:0] CC_ZERO = 3'b001;
  localparam logic [CC_W-1:0] CC_NONE = 3'b000;

endpackage

// File: rtl/sia_index_extend.sv
module sia_index_extend
  import sia_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic [XLEN-1:0] idx_in,
  input  sia_variant_e    variant,
  output logic [XLEN-1:0] idx_ext,
  output logic            illegal
);

  localparam int PAD = XLEN - WORD;

  logic [WORD-1:0] low_word;
  assign low_word = idx_in[WORD-1:0];

  always_comb begin
    illegal = 1'b0;
    unique case (variant)
      VAR_FULL:  idx_ext = idx_in;
      VAR_SWORD: idx_ext = {{PAD{low_word[WORD-1]}}, low_word};
      VAR_UWORD: idx_ext = {{PAD{1'b0}}, low_word};
      default: begin
        idx_ext = '0;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sia_shift_add.sv
module sia_shift_add #(
  parameter int XLEN    = 64,
  parameter int SCALE_W = 2
) (
  input  logic [XLEN-1:0]    base,
  input  logic [XLEN-1:0]    idx_ext,
  input  logic [SCALE_W-1:0] scale,
  output logic [XLEN-1:0]    sum
);

  localparam int AMT_W = SCALE_W + 1;

  logic [AMT_W-1:0] amount;
  logic [XLEN-1:0]  scaled;

  assign amount = AMT_W'(scale) + AMT_W'(1);
  assign scaled = idx_ext << amount;
  assign sum    = base + scaled;

endmodule

// File: rtl/sia_cond_code.sv
module sia_cond_code
  import sia_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  output logic [CC_W-1:0] code
);

  always_comb begin
    if (value[XLEN-1])    code = CC_NEG;
    else if (value == '0) code = CC_ZERO;
    else                  code = CC_POS;
  end

endmodule

// File: rtl/sia_out_stage.sv
module sia_out_stage #(
  parameter int W         = 65,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  generate
    if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign up_ready = !vld_q || dn_ready;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
        end else if (up_ready) begin
          vld_q <= up_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (up_valid && up_ready) dat_q <= up_data;
      end

      assign dn_valid = vld_q;
      assign dn_data  = dat_q;

      p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

      p_ready_rule_r9: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |-> !up_ready);

      p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready) |=> dn_valid);

      p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !dn_valid);
    end else begin : g_pass
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate

endmodule

// File: rtl/scaled_index_unit.sv
module scaled_index_unit
  import sia_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD    = 32,
  parameter int SCALE_W = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XLEN-1:0]    in_base,
  input  logic [XLEN-1:0]    in_index,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [1:0]         in_variant,
  input  logic               in_record,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XLEN-1:0]    out_result,
  output logic               out_illegal,
  output logic [CC_W-1:0]    out_cc
);

  localparam int PAY_W = XLEN + 1;

  sia_variant_e    variant;
  logic [XLEN-1:0] idx_ext;
  logic [XLEN-1:0] raw_sum;
  logic [XLEN-1:0] result;
  logic            illegal;
  logic [CC_W-1:0] cc_new;
  logic [CC_W-1:0] cc_q;
  logic            accept;
  logic            cc_load;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign variant = sia_variant_e'(in_variant);

  sia_index_extend #(.XLEN(XLEN), .WORD(WORD)) u_extend (
    .idx_in  (in_index),
    .variant (variant),
    .idx_ext (idx_ext),
    .illegal (illegal)
  );

  sia_shift_add #(.XLEN(XLEN), .SCALE_W(SCALE_W)) u_shift_add (
    .base    (in_base),
    .idx_ext (idx_ext),
    .scale   (in_scale),
    .sum     (raw_sum)
  );

  assign result = illegal ? '0 : raw_sum;

  sia_cond_code #(.XLEN(XLEN)) u_cond (
    .value (result),
    .code  (cc_new)
  );

  assign accept  = in_valid && in_ready;
  assign cc_load = accept && in_record && !illegal;

  always_ff @(posedge clk) begin
    if (rst)          cc_q <= CC_NONE;
    else if (cc_load) cc_q <= cc_new;
  end

  assign pay_in = {illegal, result};

  sia_out_stage #(.W(PAY_W), .REGISTERED(REG_OUT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_illegal = pay_out[XLEN];
  assign out_result  = pay_out[XLEN-1:0];

  generate
    if (REG_OUT) begin : g_cc_reg
      assign out_cc = cc_q;
    end else begin : g_cc_comb
      assign out_cc = cc_load ? cc_new : cc_q;
    end
  endgenerate

  p_cc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_record) |=> $stable(cc_q));

  p_rsvd_no_cc_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && variant == VAR_RSVD) |=> $stable(cc_q));

  p_cc_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cc_q));

  p_illegal_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

endmodule

// File: tb/scaled_index_unit_tb.sv
`timescale 1ns/1ps
module scaled_index_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_base;
  logic [63:0] in_index;
  logic [1:0]  in_scale;
  logic [1:0]  in_variant;
  logic        in_record;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_result;
  logic        out_illegal;
  logic [2:0]  out_cc;

  int errors = 0;
  int checks = 0;
  logic [2:0] exp_cc = 3'b000;

  always #2 clk = ~clk;

  scaled_index_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_index(in_index), .in_scale(in_scale),
    .in_variant(in_variant), .in_record(in_record), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal),
    .out_cc(out_cc)
  );

  function automatic logic [63:0] model(input logic [63:0] b, input logic [63:0] x,
                                        input logic [1:0] s, input logic [1:0] v);
    logic [63:0] e;
    case (v)
      2'd0: e = x;
      2'd1: e = {{32{x[31]}}, x[31:0]};
      2'd2: e = {32'h0, x[31:0]};
      default: return 64'h0;
    endcase
    return b + (e << (int'(s) + 1));
  endfunction

  function automatic logic [2:0] cc_of(input logic [63:0] r);
    if ($signed(r) < 0) return 3'b100;
    if (r == 64'h0)     return 3'b001;
    return 3'b010;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] b, input logic [63:0] x, input logic [1:0] s,
                        input logic [1:0] v, input logic rec, input string tag);
    logic [63:0] er;
    er = model(b, x, s, v);
    if (rec && v != 2'd3) exp_cc = cc_of(er);
    in_base = b; in_index = x; in_scale = s; in_variant = v; in_record = rec;
    in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " result"}, out_result, er);
    chk({tag, " illegal R5"}, {63'h0, out_illegal}, {63'h0, v == 2'd3});
    chk({tag, " valid R8"}, {63'h0, out_valid}, 64'h1);
    chk({tag, " cc R6/R7"}, {61'h0, out_cc}, {61'h0, exp_cc});
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] a_exp;
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_base = '0; in_index = '0; in_scale = '0; in_variant = '0; in_record = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 valid after reset", {63'h0, out_valid}, 64'h0);
    chk("R10 cc after reset", {61'h0, out_cc}, 64'h0);
    chk("R9 ready when empty", {63'h0, in_ready}, 64'h1);

    // R8: nothing appears before the capturing edge
    in_base = 64'd5; in_index = 64'd3; in_scale = 2'd0; in_variant = 2'd0;
    in_record = 1'b0; in_valid = 1'b1;
    #1 chk("R8 no same-cycle valid", {63'h0, out_valid}, 64'h0);
    in_valid = 1'b0;

    // R1: each scale code
    for (int s = 0; s < 4; s++) run_op(64'h0, 64'h1, 2'(s), 2'd0, 1'b0, "R1 scale");
    // R2: wrap and shifted-out bits
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd0, 2'd0, 1'b0, "R2 carry wrap");
    run_op(64'd5, 64'h8000_0000_0000_0001, 2'd0, 2'd0, 1'b0, "R2 shift-out");
    // R3 / R4: same index through the word variants
    run_op(64'd100, 64'h1234_5678_FFFF_FFFF, 2'd3, 2'd1, 1'b0, "R3 signed word");
    run_op(64'd0, 64'h1234_5678_FFFF_FFFF, 2'd3, 2'd1, 1'b1, "R3 R6 negative");
    run_op(64'd0, 64'h1234_5678_FFFF_FFFF, 2'd3, 2'd2, 1'b1, "R4 R6 positive");
    run_op(64'd0, 64'hFFFF_FFFF_0000_0000, 2'd1, 2'd2, 1'b1, "R4 R6 zero");
    // R5: reserved variant must not touch cc
    run_op(64'd77, 64'd9, 2'd2, 2'd3, 1'b1, "R5 reserved");
    // R7: non-record negative result leaves cc at zero code
    run_op(64'h8000_0000_0000_0000, 64'd1, 2'd0, 2'd0, 1'b0, "R7 no record");

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    a_exp = model(64'd1000, 64'd7, 2'd1, 2'd0);
    in_base = 64'd1000; in_index = 64'd7; in_scale = 2'd1; in_variant = 2'd0;
    in_record = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 first beat", out_result, a_exp);
    chk("R9 ready low under stall", {63'h0, in_ready}, 64'h0);
    in_base = 64'd1; in_index = 64'd1; in_scale = 2'd0;
    @(negedge clk);
    chk("R9 beat held", out_result, a_exp);
    chk("R9 valid held", {63'h0, out_valid}, 64'h1);
    out_ready = 1'b1;
    #1 chk("R9 ready with consumer", {63'h0, in_ready}, 64'h1);
    @(negedge clk);
    chk("R9 second beat", out_result, 64'd3);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 valid falls", {63'h0, out_valid}, 64'h0);

    // Random back-to-back traffic
    for (int i = 0; i < 400; i++) begin
      run_op({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom),
             1'($urandom), "R2 R3 R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule